// File: doc/BRIEF.md
# Shared-Memory Ring Buffer Client

This block lets hardware exchange bytes with a second processor through ring buffers kept in that processor's memory. Each ring is identified by a base address. The three bytes just below the base form a header: at base-3 the index mask (ring length minus one), at base-2 the producer (input) index and at base-1 the consumer (output) index. Data slot i sits at base+i. On one side of the ring the client is the producer, so it owns the input index. On the other side it is the consumer, so it owns the output index. The index owned by the other side is always read fresh from memory before a decision is made. Wraparound is done by AND-ing with the stored mask.

A small command port selects one of `NUM_FIFO` ring descriptors and one of six operations: initialise, empty test, full test, non-blocking get, blocking get and blocking put. Any operation that touches memory first raises a bus request and waits for the grant. It then runs its byte accesses over a valid/ack memory port, drops the request, waits for the grant to fall, and only then answers. The bus sequencer and the arbiter lie outside the block. A blocking operation that finds its ring empty or full releases the bus and requests it again, as many times as needed, until the check clears.

Top module: `ringbuf_client`

## Requirements
- R1: Operation code 0 (init) with a nonzero base reads base-3 into the local mask, base-2 into the local input index and base-1 into the local output index, in that order. It answers with flag 1.
- R2: A descriptor whose base is zero is unused. Init with base zero, every operation on an unused descriptor and the undefined codes 6 and 7 all answer without raising the bus request. Empty (code 1) answers flag 1. Full (2), get (3), blocking get (4) and put (5) answer flag 0 with data 0, and memory is left untouched.
- R3: Empty (code 1) reads base-2 and answers flag 1 exactly when that byte equals the local output index.
- R4: Full (code 2) reads base-1 and answers flag 1 exactly when ((local input index + 1) AND mask) equals that byte.
- R5: Get (code 3) reads base-2. If the ring is not empty, it reads base+out, sets out to (out+1) AND mask, writes the new out to base-1, and answers flag 1 with the byte. If the ring is empty, it answers flag 0 and makes no write.
- R6: Put (code 5) reads base-1. If the ring is not full, it writes the byte to base+in, sets in to (in+1) AND mask, writes the new in to base-2, and answers flag 1.
- R7: Blocking get (code 4) and put both repeat their check, releasing and requesting the bus again for each attempt, until the ring is no longer empty or full respectively.
- R8: The memory port is valid only while the bus request is high and the grant is high. After the last access the request drops, and the response comes only after the grant has fallen.
- R9: While the memory port is valid and not acknowledged, it holds its address, write enable and write data.
- R10: The response valid is a single-cycle pulse. Commands are taken only while ready is high. Each descriptor keeps its own indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, taken when ready is high |
| cmd_ready_o | output | 1 | Client idle and able to take a command |
| cmd_op_i | input | 3 | Operation code (0 init, 1 empty, 2 full, 3 get, 4 blocking get, 5 put) |
| cmd_fifo_i | input | SEL_W | Descriptor index |
| cmd_base_i | input | ADDR_W | Ring base address (used by init) |
| cmd_data_i | input | 8 | Byte to put |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_flag_o | output | 1 | Empty/full result, or data/success indication |
| rsp_data_o | output | 8 | Byte returned by a get |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant |
| mem_valid_o | output | 1 | Memory access pending |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_ack_i | input | 1 | Access complete, read data valid |
| mem_rdata_i | input | 8 | Read data |

## Verification
An operation on an unused descriptor is answered in the cycle after the one in which the command is accepted, so the bench checks the response at the first falling edge after it removes the command. It also checks that no bus request rose during that command. Operations that use the bus take a variable number of cycles, which depends on the grant, the acknowledge and any retries. For these the bench waits for the response pulse and samples it at a falling edge. It then compares the flag, the data, the full logged list of memory accesses and the memory contents with its own model. The bench checks the bus protocol on every clock. For the blocking cases it also checks that the wait lasted at least as long as the delay before the remote side freed the ring, and that the request was raised more than once.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned IDX_W  = 8;

  localparam int unsigned OFS_MASK = 3;
  localparam int unsigned OFS_IN   = 2;
  localparam int unsigned OFS_OUT  = 1;

  typedef enum logic [2:0] {
    OP_INIT     = 3'd0,
    OP_EMPTY    = 3'd1,
    OP_FULL     = 3'd2,
    OP_GET      = 3'd3,
    OP_GET_WAIT = 3'd4,
    OP_PUT      = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_ACC, ST_REL, ST_RSP
  } st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [IDX_W-1:0]  mask;
    logic [IDX_W-1:0]  in_idx;
    logic [IDX_W-1:0]  out_idx;
  } desc_t;
endpackage

// File: rtl/rbc_desc_file.sv
module rbc_desc_file import rbc_pkg::*; #(
  parameter int unsigned NUM_FIFO = 2,
  parameter int unsigned SEL_W    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output desc_t            desc_o,
  input  logic             wr_en_i,
  input  desc_t            wr_desc_i
);
  desc_t ent [NUM_FIFO];

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_ent
    desc_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= '0;
      else if (wr_en_i && sel_i == SEL_W'(g))     q <= wr_desc_i;
    end
    assign ent[g] = q;
  end

  // out-of-range index reads as an unused descriptor
  always_comb begin
    desc_o = '0;
    for (int i = 0; i < NUM_FIFO; i++)
      if (sel_i == SEL_W'(i)) desc_o = ent[i];
  end
endmodule

// File: rtl/rbc_addr_gen.sv
module rbc_addr_gen import rbc_pkg::*; (
  input  logic [2:0]        op_i,
  input  logic [1:0]        step_i,
  input  desc_t             desc_i,
  input  logic [IDX_W-1:0]  put_data_i,
  input  logic [IDX_W-1:0]  in_nx_i,
  input  logic [IDX_W-1:0]  out_nx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  wdata_o
);
  logic [ADDR_W-1:0] a_mask, a_in, a_out, a_rd_slot, a_wr_slot;

  assign a_mask    = desc_i.base - ADDR_W'(OFS_MASK);
  assign a_in      = desc_i.base - ADDR_W'(OFS_IN);
  assign a_out     = desc_i.base - ADDR_W'(OFS_OUT);
  assign a_rd_slot = desc_i.base + ADDR_W'(desc_i.out_idx);
  assign a_wr_slot = desc_i.base + ADDR_W'(desc_i.in_idx);

  always_comb begin
    addr_o  = a_in;
    we_o    = 1'b0;
    wdata_o = '0;
    case (op_i)
      OP_INIT:  addr_o = a_mask + ADDR_W'(step_i);
      OP_EMPTY: addr_o = a_in;
      OP_FULL:  addr_o = a_out;
      OP_GET, OP_GET_WAIT: begin
        case (step_i)
          2'd0:    addr_o = a_in;
          2'd1:    addr_o = a_rd_slot;
          default: begin addr_o = a_out; we_o = 1'b1; wdata_o = out_nx_i; end
        endcase
      end
      OP_PUT: begin
        case (step_i)
          2'd0:    addr_o = a_out;
          2'd1:    begin addr_o = a_wr_slot; we_o = 1'b1; wdata_o = put_data_i; end
          default: begin addr_o = a_in; we_o = 1'b1; wdata_o = in_nx_i; end
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rbc_seq.sv
module rbc_seq import rbc_pkg::*; #(
  parameter int unsigned SEL_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [SEL_W-1:0]  cmd_fifo_i,
  input  logic [ADDR_W-1:0] cmd_base_i,
  input  logic [IDX_W-1:0]  cmd_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_flag_o,
  output logic [IDX_W-1:0]  rsp_data_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              mem_valid_o,
  input  logic              mem_ack_i,
  input  logic [IDX_W-1:0]  mem_rdata_i,
  output logic [2:0]        op_o,
  output logic [1:0]        step_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [IDX_W-1:0]  put_data_o,
  output logic [IDX_W-1:0]  in_nx_o,
  output logic [IDX_W-1:0]  out_nx_o,
  input  desc_t             desc_i,
  output logic              desc_we_o,
  output desc_t             desc_wr_o
);
  st_e              st_q;
  logic [2:0]       op_q;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       step_q;
  logic [IDX_W-1:0] data_q, rdata_q;
  logic             flag_q, retry_q;
  logic             acked, is_get, known_op;

  assign acked    = (st_q == ST_ACC) && mem_ack_i;
  assign is_get   = (op_q == OP_GET) || (op_q == OP_GET_WAIT);
  assign known_op = cmd_op_i <= 3'(OP_PUT);

  assign in_nx_o  = (desc_i.in_idx + IDX_W'(1)) & desc_i.mask;
  assign out_nx_o = (desc_i.out_idx + IDX_W'(1)) & desc_i.mask;

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign rsp_valid_o = (st_q == ST_RSP);
  assign rsp_flag_o  = flag_q;
  assign rsp_data_o  = rdata_q;
  assign bus_req_o   = (st_q == ST_REQ) || (st_q == ST_ACC);
  assign mem_valid_o = (st_q == ST_ACC);
  assign op_o        = op_q;
  assign step_o      = step_q;
  assign put_data_o  = data_q;
  assign sel_o       = (st_q == ST_IDLE) ? cmd_fifo_i : sel_q;

  always_comb begin
    desc_we_o = 1'b0;
    desc_wr_o = desc_i;
    if (st_q == ST_IDLE && cmd_valid_i && cmd_op_i == 3'(OP_INIT)) begin
      desc_we_o = 1'b1;
      desc_wr_o = '0;
      desc_wr_o.base = cmd_base_i;
    end else if (acked) begin
      case (op_q)
        OP_INIT: begin
          desc_we_o = 1'b1;
          case (step_q)
            2'd0:    desc_wr_o.mask    = mem_rdata_i;
            2'd1:    desc_wr_o.in_idx  = mem_rdata_i;
            default: desc_wr_o.out_idx = mem_rdata_i;
          endcase
        end
        OP_GET, OP_GET_WAIT: if (step_q == 2'd2) begin
          desc_we_o = 1'b1;
          desc_wr_o.out_idx = out_nx_o;
        end
        OP_PUT: if (step_q == 2'd2) begin
          desc_we_o = 1'b1;
          desc_wr_o.in_idx = in_nx_o;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= '0;
      sel_q   <= '0;
      step_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      flag_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          op_q    <= cmd_op_i;
          sel_q   <= cmd_fifo_i;
          data_q  <= cmd_data_i;
          step_q  <= '0;
          rdata_q <= '0;
          retry_q <= 1'b0;
          flag_q  <= 1'b0;
          if (!known_op) st_q <= ST_RSP;
          else if (cmd_op_i == 3'(OP_INIT))
            st_q <= (cmd_base_i != '0) ? ST_REQ : ST_RSP;
          else if (desc_i.base == '0) begin
            flag_q <= (cmd_op_i == 3'(OP_EMPTY));
            st_q   <= ST_RSP;
          end else st_q <= ST_REQ;
        end
        ST_REQ: if (bus_gnt_i) st_q <= ST_ACC;
        ST_ACC: if (mem_ack_i) begin
          case (op_q)
            OP_INIT: begin
              if (step_q == 2'd2) begin flag_q <= 1'b1; st_q <= ST_REL; end
              else step_q <= step_q + 2'd1;
            end
            OP_EMPTY: begin
              flag_q <= (mem_rdata_i == desc_i.out_idx);
              st_q   <= ST_REL;
            end
            OP_FULL: begin
              flag_q <= (in_nx_o == mem_rdata_i);
              st_q   <= ST_REL;
            end
            OP_GET, OP_GET_WAIT: begin
              case (step_q)
                2'd0: if (mem_rdata_i == desc_i.out_idx) begin
                  flag_q  <= 1'b0;
                  retry_q <= (op_q == OP_GET_WAIT);
                  st_q    <= ST_REL;
                end else step_q <= 2'd1;
                2'd1: begin rdata_q <= mem_rdata_i; step_q <= 2'd2; end
                default: begin flag_q <= 1'b1; st_q <= ST_REL; end
              endcase
            end
            OP_PUT: begin
              case (step_q)
                2'd0: if (in_nx_o == mem_rdata_i) begin
                  retry_q <= 1'b1;
                  st_q    <= ST_REL;
                end else step_q <= 2'd1;
                2'd1: step_q <= 2'd2;
                default: begin flag_q <= 1'b1; st_q <= ST_REL; end
              endcase
            end
            default: st_q <= ST_REL;
          endcase
        end
        ST_REL: if (!bus_gnt_i) begin
          if (retry_q) begin
            retry_q <= 1'b0;
            step_q  <= '0;
            st_q    <= ST_REQ;
          end else st_q <= ST_RSP;
        end
        ST_RSP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ACC_UNDER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> bus_req_o && bus_gnt_i); // R8
  AST_RSP_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !bus_req_o && !mem_valid_o); // R8
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R10
  AST_UNUSED_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_ready_o && cmd_valid_i && cmd_op_i != 3'(OP_INIT) && desc_i.base == '0)
      |=> !bus_req_o && rsp_valid_o); // R2
  AST_OUT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acked && is_get && step_q == 2'd2)
      |=> desc_i.out_idx == (($past(desc_i.out_idx) + IDX_W'(1)) & $past(desc_i.mask))); // R5
endmodule

// File: rtl/ringbuf_client.sv
module ringbuf_client import rbc_pkg::*; #(
  parameter int unsigned NUM_FIFO = 2,
  localparam int unsigned SEL_W   = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [SEL_W-1:0]  cmd_fifo_i,
  input  logic [ADDR_W-1:0] cmd_base_i,
  input  logic [IDX_W-1:0]  cmd_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_flag_o,
  output logic [IDX_W-1:0]  rsp_data_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [IDX_W-1:0]  mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [IDX_W-1:0]  mem_rdata_i
);
  logic [2:0]       op;
  logic [1:0]       step;
  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] put_data, in_nx, out_nx;
  desc_t            desc, desc_wr;
  logic             desc_we;

  rbc_desc_file #(.NUM_FIFO(NUM_FIFO), .SEL_W(SEL_W)) u_desc (
    .clk_i, .rst_ni, .sel_i(sel), .desc_o(desc),
    .wr_en_i(desc_we), .wr_desc_i(desc_wr)
  );

  rbc_seq #(.SEL_W(SEL_W)) u_seq (
    .clk_i, .rst_ni,
    .cmd_valid_i, .cmd_ready_o, .cmd_op_i, .cmd_fifo_i, .cmd_base_i, .cmd_data_i,
    .rsp_valid_o, .rsp_flag_o, .rsp_data_o,
    .bus_req_o, .bus_gnt_i, .mem_valid_o, .mem_ack_i, .mem_rdata_i,
    .op_o(op), .step_o(step), .sel_o(sel), .put_data_o(put_data),
    .in_nx_o(in_nx), .out_nx_o(out_nx),
    .desc_i(desc), .desc_we_o(desc_we), .desc_wr_o(desc_wr)
  );

  rbc_addr_gen u_addr (
    .op_i(op), .step_i(step), .desc_i(desc), .put_data_i(put_data),
    .in_nx_i(in_nx), .out_nx_i(out_nx),
    .addr_o(mem_addr_o), .we_o(mem_we_o), .wdata_o(mem_wdata_o)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ack_i) |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)); // R9
  AST_SLOT_WRITE_AFTER_CHECK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && mem_we_o) |-> bus_gnt_i && step != 2'd0); // R6
endmodule

// File: tb/ringbuf_client_tb_top.sv
module ringbuf_client_tb_top;
  import rbc_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [0:0]  cmd_fifo = '0;
  logic [15:0] cmd_base = '0;
  logic [7:0]  cmd_data = '0;
  logic        rsp_valid, rsp_flag;
  logic [7:0]  rsp_data;
  logic        bus_req, bus_gnt = 1'b0;
  logic        mem_valid, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;

  ringbuf_client dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
    .cmd_fifo_i(cmd_fifo), .cmd_base_i(cmd_base), .cmd_data_i(cmd_data),
    .rsp_valid_o(rsp_valid), .rsp_flag_o(rsp_flag), .rsp_data_o(rsp_data),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  logic [7:0]  mem [0:4095];
  logic [31:0] acc_log [$];
  logic [31:0] exp_log [$];
  int checks = 0, fails = 0, req_rises = 0;
  logic req_d = 1'b0;

  function automatic logic [31:0] acc(input logic we, input logic [15:0] a, input logic [7:0] d);
    return {we, 7'd0, a, d};
  endfunction

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // remote memory, arbiter and protocol monitor, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_valid) check("R8 access outside grant", bus_req && bus_gnt, {bus_req, bus_gnt}, 3);
      if (bus_req && !req_d) req_rises++;
      req_d = bus_req;
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_valid) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr[11:0]] = mem_wdata;
          acc_log.push_back(acc(1'b1, mem_addr, mem_wdata));
        end else begin
          mem_rdata = mem[mem_addr[11:0]];
          acc_log.push_back(acc(1'b0, mem_addr, mem_rdata));
        end
      end
      bus_gnt = bus_req;
    end
  end

  task automatic run_cmd(input logic [2:0] op, input logic f, input logic [15:0] base,
                         input logic [7:0] d, output logic fl, output logic [7:0] dat, output int lat);
    @(negedge clk);
    acc_log.delete();
    req_rises = 0;
    cmd_op = op; cmd_fifo = f; cmd_base = base; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    fl = rsp_flag; dat = rsp_data;
  endtask

  task automatic chk_log(input string tag);
    check({tag, " access count"}, acc_log.size() == exp_log.size(), acc_log.size(), exp_log.size());
    if (acc_log.size() == exp_log.size())
      foreach (exp_log[i]) check({tag, " access"}, acc_log[i] == exp_log[i], acc_log[i], exp_log[i]);
    exp_log.delete();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic fl; logic [7:0] dat; int lat;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset ready", cmd_ready == 1'b1, cmd_ready, 1);
    check("R8 reset idle bus", {bus_req, mem_valid, rsp_valid} == 3'b000, {bus_req, mem_valid, rsp_valid}, 0);

    // R2 unused descriptor after reset
    run_cmd(3'd1, 1'b0, 16'h0, 8'h0, fl, dat, lat);
    check("R2 unused empty", fl == 1'b1 && lat == 0 && req_rises == 0, {fl, 4'(lat)}, 16);
    run_cmd(3'd2, 1'b0, 16'h0, 8'h0, fl, dat, lat);
    check("R2 unused full", fl == 1'b0 && lat == 0 && req_rises == 0, {fl, 4'(lat)}, 0);
    run_cmd(3'd3, 1'b1, 16'h0, 8'h0, fl, dat, lat);
    check("R2 unused get", {fl, dat} == 9'd0 && req_rises == 0, {fl, dat}, 0);
    run_cmd(3'd5, 1'b1, 16'h0, 8'h5A, fl, dat, lat);
    check("R2 unused put", fl == 1'b0 && req_rises == 0 && acc_log.size() == 0, acc_log.size(), 0);
    run_cmd(3'd7, 1'b0, 16'h0, 8'h0, fl, dat, lat);
    check("R10 undefined op", fl == 1'b0 && lat == 0 && req_rises == 0, {fl, 4'(lat)}, 0);

    // R1 init ring 0: mask 7, in 2, out 2
    mem[12'h0FD] = 8'h07; mem[12'h0FE] = 8'h02; mem[12'h0FF] = 8'h02;
    run_cmd(3'd0, 1'b0, 16'h0100, 8'h0, fl, dat, lat);
    check("R1 init flag", fl == 1'b1, fl, 1);
    exp_log = '{acc(0, 16'h00FD, 8'h07), acc(0, 16'h00FE, 8'h02), acc(0, 16'h00FF, 8'h02)};
    chk_log("R1 init");

    run_cmd(3'd1, 1'b0, 16'h0, 8'h0, fl, dat, lat);
    check("R3 empty true", fl == 1'b1, fl, 1);
    exp_log = '{acc(0, 16'h00FE, 8'h02)};
    chk_log("R3 empty");
    run_cmd(3'd3, 1'b0, 16'h0, 8'h0, fl, dat, lat);
    check("R5 get on empty", fl == 1'b0, fl, 0);
    exp_log = '{acc(0, 16'h00FE, 8'h02)};
    chk_log("R5 empty get");

    run_cmd(3'd5, 1'b0, 16'h0, 8'hA5, fl, dat, lat);
    check("R6 put flag", fl == 1'b1, fl, 1);
    exp_log = '{acc(0, 16'h00FF, 8'h02), acc(1, 16'h0102, 8'hA5), acc(1, 16'h00FE, 8'h03)};
    chk_log("R6 put");

    run_cmd(3'd1, 1'b0, 16'h0, 8'h0, fl, dat, lat);
    check("R3 empty false", fl == 1'b0, fl, 0);
    exp_log = '{acc(0, 16'h00FE, 8'h03)};
    chk_log("R3 not empty");

    run_cmd(3'd3, 1'b0, 16'h0, 8'h0, fl, dat, lat);
    check("R5 get data", {fl, dat} == {1'b1, 8'hA5}, {fl, dat}, 9'h1A5);
    exp_log = '{acc(0, 16'h00FE, 8'h03), acc(0, 16'h0102, 8'hA5), acc(1, 16'h00FF, 8'h03)};
    chk_log("R5 get");

    // ring 1: mask 3, in 3, out 0 -> full
    mem[12'h1FD] = 8'h03; mem[12'h1FE] = 8'h03; mem[12'h1FF] = 8'h00;
    run_cmd(3'd0, 1'b1, 16'h0200, 8'h0, fl, dat, lat);
    exp_log = '{acc(0, 16'h01FD, 8'h03), acc(0, 16'h01FE, 8'h03), acc(0, 16'h01FF, 8'h00)};
    chk_log("R1 init ring1");
    run_cmd(3'd2, 1'b1, 16'h0, 8'h0, fl, dat, lat);
    check("R4 full true", fl == 1'b1, fl, 1);
    mem[12'h1FF] = 8'h01;
    run_cmd(3'd2, 1'b1, 16'h0, 8'h0, fl, dat, lat);
    check("R4 full false", fl == 1'b0, fl, 0);
    run_cmd(3'd5, 1'b1, 16'h0, 8'h5C, fl, dat, lat);
    exp_log = '{acc(0, 16'h01FF, 8'h01), acc(1, 16'h0203, 8'h5C), acc(1, 16'h01FE, 8'h00)};
    chk_log("R6 put wrap");

    // R7 blocking put on full ring 1 (in 0, out 1)
    fork begin repeat (40) @(negedge clk); mem[12'h1FF] = 8'h02; end join_none
    run_cmd(3'd5, 1'b1, 16'h0, 8'h77, fl, dat, lat);
    check("R7 put waited", lat >= 38 && req_rises > 1, lat, 38);
    check("R6 blocking put data", mem[12'h200] == 8'h77 && mem[12'h1FE] == 8'h01, {mem[12'h200], mem[12'h1FE]}, 16'h7701);

    // R7 blocking get on empty ring 0 (in 3, out 3)
    fork begin repeat (30) @(negedge clk); mem[12'h103] = 8'h3C; mem[12'h0FE] = 8'h04; end join_none
    run_cmd(3'd4, 1'b0, 16'h0, 8'h0, fl, dat, lat);
    check("R7 get waited", lat >= 28 && req_rises > 1, lat, 28);
    check("R7 blocking get data", {fl, dat} == {1'b1, 8'h3C} && mem[12'h0FF] == 8'h04, {fl, dat}, 9'h13C);

    // R5 output index wrap: mask 7, in 0, out 7
    mem[12'h0FD] = 8'h07; mem[12'h0FE] = 8'h00; mem[12'h0FF] = 8'h07; mem[12'h107] = 8'h99;
    run_cmd(3'd0, 1'b0, 16'h0100, 8'h0, fl, dat, lat);
    exp_log.delete(); acc_log.delete();
    run_cmd(3'd3, 1'b0, 16'h0, 8'h0, fl, dat, lat);
    check("R5 wrap data", {fl, dat} == {1'b1, 8'h99}, {fl, dat}, 9'h199);
    exp_log = '{acc(0, 16'h00FE, 8'h00), acc(0, 16'h0107, 8'h99), acc(1, 16'h00FF, 8'h00)};
    chk_log("R5 wrap");

    // R10 ring 1 keeps its own indices (local out 0, remote in 1)
    run_cmd(3'd1, 1'b1, 16'h0, 8'h0, fl, dat, lat);
    check("R10 ring1 independent", fl == 1'b0, fl, 0);

    // R2 init with zero base disables ring 0
    run_cmd(3'd0, 1'b0, 16'h0000, 8'h0, fl, dat, lat);
    check("R2 zero-base init", fl == 1'b0 && lat == 0 && req_rises == 0, {fl, 4'(lat)}, 0);
    run_cmd(3'd1, 1'b0, 16'h0, 8'h0, fl, dat, lat);
    check("R2 disabled empty", fl == 1'b1 && req_rises == 0, fl, 1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule